// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the memory operand address for a load/store datapath from a base register value, a signed constant taken from the instruction word, an access size and a two-bit addressing mode. It supports four modes: plain register indirect, indexed, post-increment and pre-decrement. In the two stepping modes it also returns an updated base value and a write-back strobe in the same cycle as the address, so the register file can retire the pointer update together with the access.

A request is qualified by `valid_i`. The unit registers the result, so the address, write-back value and strobes appear one clock after the request is accepted. A stack pointer used for word pushes (pre-decrement by four, then store) and word pops (load, then post-increment by four) is the main use of the stepping modes.

Top module: `eagu_top`

## Requirements
- R1: Mode 2'b00 (indirect): the address equals the base value, and no write-back is requested.
- R2: Mode 2'b01 (indexed): the address equals the base plus the 16-bit offset sign-extended to 32 bits. The base is not written back.
- R3: Mode 2'b10 (post-increment): the address equals the unmodified base, and the write-back value equals the base plus the step.
- R4: Mode 2'b11 (pre-decrement): the write-back value equals the base minus the step, and the address equals that decremented value.
- R5: The step is set by the size code: 2'b00 gives 1 (byte), 2'b01 gives 2 (halfword), and 2'b10 or 2'b11 give 4 (word).
- R6: `wb_en_o` is high only for an accepted request in mode 2'b10 or 2'b11.
- R7: All sums and differences wrap modulo 2^32 with no other effect.
- R8: Outputs change one clock after a cycle with `valid_i` high. After a cycle with `valid_i` low, `valid_o` and `wb_en_o` are low. During and after reset, all outputs are zero.
- R9: A word push (pre-decrement, size word) from a stack pointer, followed by a word pop (post-increment, size word) of its write-back, gives the same address for both. The pop's write-back restores the original pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request qualifier |
| mode_i | input | 2 | Addressing mode |
| size_i | input | 2 | Access size code |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed constant from the instruction |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base register write-back strobe |
| wb_data_o | output | 32 | Updated base value |

## Verification
In the stepping modes, the address and the base write-back are produced in the same cycle, and their order is what separates the two modes. Pre-decrement must show the already-stepped value on both outputs, while post-increment shows the old base as the address and the stepped base as the write-back. The bench sweeps every mode and size over bases near zero, near the top of the address space and in the middle, and compares both outputs in the same sample against sums computed in the bench. A push followed by a pop on the returned pointer checks that the two accesses hit the same word and that the pointer returns to where it started.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  typedef enum logic [1:0] {
    MODE_IND = 2'b00,
    MODE_IDX = 2'b01,
    MODE_INC = 2'b10,
    MODE_DEC = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } size_e;
endpackage

// File: rtl/eagu_sext.sv
module eagu_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] ext_o
);
  generate
    if (IN_W >= OUT_W) begin : g_trunc
      assign ext_o = val_i[OUT_W-1:0];
    end else begin : g_ext
      localparam int PAD_W = OUT_W - IN_W;
      assign ext_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/eagu_step.sv
module eagu_step
  import eagu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   size_i,
  output logic [W-1:0] step_o
);
  always_comb begin
    step_o = '0;
    unique case (size_e'(size_i))
      SZ_BYTE: step_o[0] = 1'b1;
      SZ_HALF: step_o[1] = 1'b1;
      default: step_o[2] = 1'b1;
    endcase
  end
endmodule

// File: rtl/eagu_addsub.sv
module eagu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  // subtract as a + ~b + 1, wraps modulo 2^W
  logic [W-1:0] b_x;
  assign b_x = sub_i ? ~b_i : b_i;
  assign y_o = a_i + b_x + {{(W-1){1'b0}}, sub_i};
endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_data_o
);
  mode_e             mode;
  logic [ADDR_W-1:0] off_ext, step, idx_sum, step_sum;
  logic [ADDR_W-1:0] addr_d, wb_d;
  logic              wb_en_d;

  assign mode = mode_e'(mode_i);

  eagu_sext #(.IN_W(OFF_W), .OUT_W(ADDR_W)) u_sext (
    .val_i (offset_i),
    .ext_o (off_ext)
  );

  eagu_step #(.W(ADDR_W)) u_step (
    .size_i (size_i),
    .step_o (step)
  );

  // index adder: base + offset
  eagu_addsub #(.W(ADDR_W)) u_idx_add (
    .a_i   (base_i),
    .b_i   (off_ext),
    .sub_i (1'b0),
    .y_o   (idx_sum)
  );

  // pointer adder: base +/- step
  eagu_addsub #(.W(ADDR_W)) u_ptr_add (
    .a_i   (base_i),
    .b_i   (step),
    .sub_i (mode == MODE_DEC),
    .y_o   (step_sum)
  );

  always_comb begin
    addr_d  = base_i;
    wb_d    = step_sum;
    wb_en_d = 1'b0;
    unique case (mode)
      MODE_IND: addr_d = base_i;
      MODE_IDX: addr_d = idx_sum;
      MODE_INC: begin
        addr_d  = base_i;  // access first, then update
        wb_en_d = 1'b1;
      end
      MODE_DEC: begin
        addr_d  = step_sum;  // update first, then access
        wb_en_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wb_en_o   <= 1'b0;
      addr_o    <= '0;
      wb_data_o <= '0;
    end else begin
      valid_o <= valid_i;
      wb_en_o <= valid_i & wb_en_d;
      if (valid_i) begin
        addr_o    <= addr_d;
        wb_data_o <= wb_d;
      end
    end
  end
endmodule

// File: rtl/eagu_chk.sv
module eagu_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              wb_en_o,
  input logic [ADDR_W-1:0] wb_data_o
);
  p_ind_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'b00 |=> addr_o == $past(base_i) && !wb_en_o);

  p_inc_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'b10 |=> addr_o == $past(base_i) && wb_en_o);

  p_dec_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == 2'b11 |=> addr_o == wb_data_o && wb_en_o);

  p_wb_auto_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i[1] |=> !wb_en_o);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wb_en_o);

  p_wb_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o);
endmodule

bind eagu_top eagu_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .base_i    (base_i),
  .valid_o   (valid_o),
  .addr_o    (addr_o),
  .wb_en_o   (wb_en_o),
  .wb_data_o (wb_data_o)
);

// File: tb/tb_eagu_top.sv
module tb_eagu_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic        valid_o, wb_en_o;
  logic [31:0] addr_o, wb_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  eagu_top dut (
    .clk_i, .rst_ni, .valid_i, .mode_i, .size_i, .base_i, .offset_i,
    .valid_o, .addr_o, .wb_en_o, .wb_data_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;  // R5
  endfunction

  // called at a negedge; returns at the next negedge with outputs checked
  task automatic run(input logic [1:0] md, input logic [1:0] sz,
                     input logic [31:0] b, input logic [15:0] off,
                     output logic [31:0] a_got, output logic [31:0] w_got);
    logic [31:0] st, ea, wv, sx;
    logic        we;
    valid_i = 1'b1; mode_i = md; size_i = sz; base_i = b; offset_i = off;
    st = step_of(sz);
    sx = {{16{off[15]}}, off};
    we = md[1];
    wv = 32'h0;
    case (md)
      2'b00: ea = b;
      2'b01: ea = b + sx;
      2'b10: begin ea = b; wv = b + st; end
      default: begin wv = b - st; ea = wv; end
    endcase
    @(negedge clk_i);
    a_got = addr_o;
    w_got = wb_data_o;
    chk("R8 valid", {31'b0, valid_o}, 32'd1);
    case (md)
      2'b00: chk("R1 addr", addr_o, ea);
      2'b01: chk("R2 addr", addr_o, ea);
      2'b10: chk("R3 addr", addr_o, ea);
      default: chk("R4 addr", addr_o, ea);
    endcase
    chk("R6 wb_en", {31'b0, wb_en_o}, {31'b0, we});
    if (we) chk(md == 2'b10 ? "R3 R5 R7 wb" : "R4 R5 R7 wb", wb_data_o, wv);
  endtask

  initial begin
    logic [31:0] bases [6] = '{32'h0, 32'h1, 32'h0000_1000, 32'h8000_0000,
                               32'hFFFF_FFFE, 32'hFFFF_FFFF};
    logic [15:0] offs [5] = '{16'h0000, 16'h0004, 16'h7FFF, 16'h8000, 16'hFFFC};
    logic [31:0] a, w, sp, push_a;
    #1;
    chk("R8 reset valid", {31'b0, valid_o}, 32'd0);
    chk("R8 reset addr", addr_o, 32'd0);
    chk("R8 reset wb", wb_data_o, 32'd0);
    chk("R8 reset wb_en", {31'b0, wb_en_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int bi = 0; bi < 6; bi++)
          for (int oi = 0; oi < 5; oi++)
            run(m[1:0], s[1:0], bases[bi], offs[oi], a, w);

    // idle cycle after a stepping request: R8 R6
    run(2'b11, 2'b10, 32'h100, 16'h0, a, w);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R8 idle valid", {31'b0, valid_o}, 32'd0);
    chk("R6 idle wb_en", {31'b0, wb_en_o}, 32'd0);

    // stack profile: R9
    sp = 32'h0000_2000;
    run(2'b11, 2'b10, sp, 16'h0, push_a, w);
    chk("R9 push addr", push_a, 32'h0000_1FFC);
    sp = w;
    run(2'b11, 2'b10, sp, 16'h0, a, w);
    chk("R9 second push", a, 32'h0000_1FF8);
    sp = w;
    run(2'b01, 2'b10, sp, 16'h0004, a, w);
    chk("R9 R2 frame field", a, 32'h0000_1FFC);
    run(2'b10, 2'b10, sp, 16'h0, a, w);
    chk("R9 pop addr", a, 32'h0000_1FF8);
    sp = w;
    run(2'b10, 2'b10, sp, 16'h0, a, w);
    chk("R9 pop matches push", a, push_a);
    chk("R9 sp restored", w, 32'h0000_2000);

    valid_i = 1'b0;
    @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule